// File: doc/BRIEF.md
# Phase-Zero SPI Master

This block is a full-duplex serial peripheral master that moves exactly one data word inside each slave-select frame, using the phase-zero clocking scheme. A local requester presents a parallel transmit word, a slave index and a one-cycle start strobe. The block pulls the chosen select line low and places the first transmit bit on MOSI right away. It then runs the serial clock and shifts the word out while it shifts the reply in from MISO. When the frame closes, it returns the received word together with a one-cycle done pulse.

Clock polarity, bit order and word width (8, 16 or 32 bits) come from configuration inputs. They are sampled when a start is accepted and held for the whole frame. The serial clock period is a fixed even number of system clocks, `SYS_DIV`, so half an SCK period lasts `H = SYS_DIV/2` system cycles. The controller is a state machine with six states. IDLE waits for a start. SETUP holds SCK idle with select active. LEAD holds SCK at its active level. TRAIL holds SCK idle between bits. HOLD holds SCK idle after the last bit while select stays active. GAP keeps select released before the next frame.

The transitions are: IDLE to SETUP when a start is accepted. SETUP to LEAD after H cycles, which is the leading edge where MISO is sampled. LEAD to TRAIL after H cycles when bits remain, which is the trailing edge where MOSI advances. LEAD to HOLD after H cycles on the last bit. TRAIL to LEAD after H cycles. HOLD to GAP after H cycles, where select releases and done pulses. GAP to IDLE after H cycles.

Top module: `spi_cpha0_master`

## Requirements
- R1: After reset, every select output is high, `done_o` and `busy_o` are low, and `sck_o` equals `cfg_cpol_i`.
- R2: A start accepted in IDLE drives low, from the next clock, only select bit `slave_i`. At that same clock, MOSI already carries the first transmit bit.
- R3: SCK stays at its idle level for exactly H system cycles after select goes low, and then makes its first (leading) transition.
- R4: A frame contains exactly N leading edges, where N is 8, 16 or 32. Every SCK level between the first leading edge and the last trailing edge lasts exactly H cycles.
- R5: MISO is captured on each leading edge. MOSI changes only on trailing edges, so it is stable across every leading edge.
- R6: The idle level of SCK equals the polarity bit: low when 0, high when 1. SCK never toggles while all select lines are high.
- R7: With `cfg_lsb_first_i`=0, bits go out and come in most significant first. With 1, they go least significant first.
- R8: The width code `cfg_width_i` selects 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. Transmit bits above the width are not sent, and received bits above the width read as zero.
- R9: H cycles after the last leading edge, SCK returns to idle. H cycles after that, select goes high, and in that same cycle `done_o` pulses for one cycle with the received word on `rx_data_o`.
- R10: A start that arrives while `busy_o` is high is ignored. It changes neither the current frame nor its select line, and it starts no extra frame.
- R11: Between two frames, the select lines stay high for at least H cycles. Each word therefore gets its own select assertion, even when two words go to the same slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| slave_i | input | SEL_W | Index of the slave to select |
| tx_data_i | input | 32 | Transmit word, right-aligned |
| cfg_width_i | input | 2 | Word width code |
| cfg_lsb_first_i | input | 1 | 1 = least significant bit first |
| cfg_cpol_i | input | 1 | SCK idle level |
| busy_o | output | 1 | Frame in progress (SETUP through GAP) |
| done_o | output | 1 | One-cycle pulse: received word valid |
| rx_data_o | output | 32 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_SLAVES | Active-low slave selects |

## Verification
If the state register or the half-period counter goes wrong, the fault shows on `sck_o` or `cs_n_o` within one half period (H cycles): an SCK level of the wrong length, a missing setup delay, or select releasing early. The bench measures each of these intervals. A wrong bit counter or shift direction changes the number of leading edges or the bit order. A slave model in the bench serialises its own word, so such a fault shows as a mismatched received or transmitted word at the done pulse that closes the same frame. A start that leaks in while busy would change the select pattern or open a frame with no matching entry in the scoreboard, and that is flagged at the next select edge.

// File: rtl/spi_cpha0_pkg.sv
package spi_cpha0_pkg;

    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32B = 2'd3
    } wid_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP
    } st_e;

    function automatic logic [5:0] wid_bits(input logic [1:0] code);
        unique case (wid_e'(code))
            WID_8:   return 6'd8;
            WID_16:  return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [MAX_W-1:0] wid_mask(input logic [1:0] code);
        unique case (wid_e'(code))
            WID_8:   return 32'h0000_00FF;
            WID_16:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/spi_cpha0_halfcnt.sv
module spi_cpha0_halfcnt #(
    parameter int HALF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic half_end_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign half_end_o = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i || half_end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_HALF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(HALF - 1)); // R4

    AST_HALF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (half_end_o && !clear_i) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/spi_cpha0_shifter.sv
module spi_cpha0_shifter
    import spi_cpha0_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [MAX_W-1:0] load_data_i,
    input  logic [1:0]       load_wid_i,
    input  logic             load_lsb_i,
    input  logic [1:0]       wid_i,
    input  logic             lsb_i,
    input  logic             advance_i,
    input  logic             sample_i,
    input  logic             capture_i,
    input  logic             miso_i,
    output logic             mosi_o,
    output logic [MAX_W-1:0] rx_data_o
);
    logic [MAX_W-1:0] tx_sr_q;
    logic [MAX_W-1:0] rx_sr_q;
    logic [5:0]       load_gap;
    logic [5:0]       run_gap;

    assign load_gap = 6'd32 - wid_bits(load_wid_i);
    assign run_gap  = 6'd32 - wid_bits(wid_i);
    assign mosi_o   = lsb_i ? tx_sr_q[0] : tx_sr_q[MAX_W-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_sr_q <= '0;
        end else if (load_i) begin
            if (load_lsb_i) begin
                tx_sr_q <= load_data_i & wid_mask(load_wid_i);
            end else begin
                tx_sr_q <= load_data_i << load_gap;
            end
        end else if (advance_i) begin
            tx_sr_q <= lsb_i ? (tx_sr_q >> 1) : (tx_sr_q << 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_sr_q <= '0;
        end else if (load_i) begin
            rx_sr_q <= '0;
        end else if (sample_i) begin
            rx_sr_q <= lsb_i ? {miso_i, rx_sr_q[MAX_W-1:1]}
                             : {rx_sr_q[MAX_W-2:0], miso_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_data_o <= '0;
        end else if (capture_i) begin
            rx_data_o <= lsb_i ? (rx_sr_q >> run_gap) : (rx_sr_q & wid_mask(wid_i));
        end
    end

    AST_RX_FITS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(capture_i) |-> ((rx_data_o & ~wid_mask(wid_i)) == '0)); // R8

endmodule

// File: rtl/spi_cpha0_ctrl.sv
module spi_cpha0_ctrl
    import spi_cpha0_pkg::*;
#(
    parameter int NUM_SLAVES = 4,
    parameter int SEL_W      = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [SEL_W-1:0]      slave_i,
    input  logic [1:0]            cfg_width_i,
    input  logic                  cfg_lsb_first_i,
    input  logic                  cfg_cpol_i,
    input  logic                  half_end_i,
    output logic                  busy_o,
    output logic                  cnt_clear_o,
    output logic                  load_o,
    output logic                  sample_o,
    output logic                  advance_o,
    output logic                  capture_o,
    output logic                  sck_act_o,
    output logic [NUM_SLAVES-1:0] cs_n_o,
    output logic                  done_o,
    output logic [1:0]            wid_o,
    output logic                  lsb_o,
    output logic                  cpol_o
);
    st_e state_q, state_d;
    logic [5:0]            bits_left_q;
    logic                  last_bit;
    logic                  accept;
    logic [NUM_SLAVES-1:0] sel_dec;

    for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_dec
        assign sel_dec[g] = (slave_i == SEL_W'(g));
    end

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign last_bit    = (bits_left_q == 6'd0);
    assign busy_o      = (state_q != ST_IDLE);
    assign cnt_clear_o = (state_q == ST_IDLE);
    assign load_o      = accept;
    assign sample_o    = half_end_i && ((state_q == ST_SETUP) || (state_q == ST_TRAIL));
    assign advance_o   = half_end_i && (state_q == ST_LEAD) && !last_bit;
    assign capture_o   = half_end_i && (state_q == ST_HOLD);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)    state_d = ST_SETUP;
            ST_SETUP: if (half_end_i) state_d = ST_LEAD;
            ST_LEAD:  if (half_end_i) state_d = last_bit ? ST_HOLD : ST_TRAIL;
            ST_TRAIL: if (half_end_i) state_d = ST_LEAD;
            ST_HOLD:  if (half_end_i) state_d = ST_GAP;
            ST_GAP:   if (half_end_i) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_n_o      <= '1;
            sck_act_o   <= 1'b0;
            done_o      <= 1'b0;
            bits_left_q <= '0;
            wid_o       <= '0;
            lsb_o       <= 1'b0;
            cpol_o      <= 1'b0;
        end else begin
            done_o <= capture_o;
            if (accept) begin
                cs_n_o      <= ~sel_dec;
                bits_left_q <= wid_bits(cfg_width_i) - 6'd1;
                wid_o       <= cfg_width_i;
                lsb_o       <= cfg_lsb_first_i;
                cpol_o      <= cfg_cpol_i;
            end
            if (sample_o) begin
                sck_act_o <= 1'b1;
            end
            if (half_end_i && (state_q == ST_LEAD)) begin
                sck_act_o <= 1'b0;
                if (!last_bit) bits_left_q <= bits_left_q - 6'd1;
            end
            if (capture_o) begin
                cs_n_o <= '1;
            end
        end
    end

    AST_CS_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~cs_n_o) <= 1); // R2

    AST_IGNORE_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> ($stable(wid_o) && $stable(lsb_o) && $stable(cpol_o))); // R10

    AST_DONE_AT_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((&cs_n_o) && !$past(&cs_n_o))); // R9

    AST_SCK_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sck_act_o |-> busy_o); // R6

    AST_NO_RESELECT_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(&cs_n_o)) |=> (&cs_n_o)); // R11

endmodule

// File: rtl/spi_cpha0_master.sv
module spi_cpha0_master
    import spi_cpha0_pkg::*;
#(
    parameter int SYS_DIV    = 4,
    parameter int NUM_SLAVES = 4,
    parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [SEL_W-1:0]      slave_i,
    input  logic [MAX_W-1:0]      tx_data_i,
    input  logic [1:0]            cfg_width_i,
    input  logic                  cfg_lsb_first_i,
    input  logic                  cfg_cpol_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [MAX_W-1:0]      rx_data_o,
    output logic                  sck_o,
    output logic                  mosi_o,
    input  logic                  miso_i,
    output logic [NUM_SLAVES-1:0] cs_n_o
);
    localparam int HALF = SYS_DIV / 2;

    logic       half_end, cnt_clear, load, sample, advance, capture, sck_act;
    logic [1:0] wid_q;
    logic       lsb_q, cpol_q;

    spi_cpha0_halfcnt #(.HALF(HALF)) u_half (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (cnt_clear),
        .half_end_o (half_end)
    );

    spi_cpha0_ctrl #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) u_ctrl (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .start_i         (start_i),
        .slave_i         (slave_i),
        .cfg_width_i     (cfg_width_i),
        .cfg_lsb_first_i (cfg_lsb_first_i),
        .cfg_cpol_i      (cfg_cpol_i),
        .half_end_i      (half_end),
        .busy_o          (busy_o),
        .cnt_clear_o     (cnt_clear),
        .load_o          (load),
        .sample_o        (sample),
        .advance_o       (advance),
        .capture_o       (capture),
        .sck_act_o       (sck_act),
        .cs_n_o          (cs_n_o),
        .done_o          (done_o),
        .wid_o           (wid_q),
        .lsb_o           (lsb_q),
        .cpol_o          (cpol_q)
    );

    spi_cpha0_shifter u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .load_data_i (tx_data_i),
        .load_wid_i  (cfg_width_i),
        .load_lsb_i  (cfg_lsb_first_i),
        .wid_i       (wid_q),
        .lsb_i       (lsb_q),
        .advance_i   (advance),
        .sample_i    (sample),
        .capture_i   (capture),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_data_o   (rx_data_o)
    );

    assign sck_o = busy_o ? (cpol_q ^ sck_act) : cfg_cpol_i;

    AST_MOSI_STEADY_AT_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sck_act) |-> $stable(mosi_o)); // R5

    AST_SETUP_BEFORE_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(&cs_n_o) |-> !sck_act); // R3

endmodule

// File: tb/spi_cpha0_master_tb.sv
module spi_cpha0_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int NS   = 4;

    typedef struct {
        logic [31:0] tx;
        logic [31:0] mw;
        int          n;
        bit          lsb;
        bit          cpol;
        int          slave;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  slave = '0;
    logic [31:0] tx_data = '0;
    logic [1:0]  cfg_width = '0;
    logic        cfg_lsb = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        busy, done, sck, mosi;
    logic        miso = 1'b0;
    logic [31:0] rx_data;
    logic [NS-1:0] cs_n;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cpha0_master #(.SYS_DIV(DIV), .NUM_SLAVES(NS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .slave_i(slave),
        .tx_data_i(tx_data), .cfg_width_i(cfg_width), .cfg_lsb_first_i(cfg_lsb),
        .cfg_cpol_i(cfg_cpol), .busy_o(busy), .done_o(done), .rx_data_o(rx_data),
        .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nbits(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic bit_at(input exp_t e, input int k);
        return e.lsb ? e.mw[k] : e.mw[e.n-1-k];
    endfunction

    // Monitor, slave model and scoreboard
    logic [NS-1:0] prev_cs = '1;
    logic          prev_sck = 1'b0;
    int            run = 0;
    bit            in_frame = 0;
    int            lead_cnt = 0;
    int            sidx = 0;
    logic [31:0]   srx = '0;
    int            frames = 0;
    exp_t          cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n != prev_cs) begin
                if (prev_cs == '1) begin
                    if (q.size() == 0) begin
                        chk(0, "R10 unexpected frame", {28'd0, cs_n}, 32'hF);
                    end else begin
                        cur = q[0];
                        if (frames > 0) chk(run >= HALF, "R11 deselect gap", run, HALF);
                        chk(cs_n == ~(NS'(1) << cur.slave), "R2 select pattern", {28'd0, cs_n}, {28'd0, ~(NS'(1) << cur.slave)});
                        chk(sck == cur.cpol, "R3 sck idle at select", sck, cur.cpol);
                        chk(mosi == (cur.lsb ? cur.tx[0] : cur.tx[cur.n-1]), "R2 first bit", mosi, cur.lsb ? cur.tx[0] : cur.tx[cur.n-1]);
                        in_frame = 1; lead_cnt = 0; sidx = 0; srx = '0;
                        miso = bit_at(cur, 0);
                    end
                end else if (cs_n == '1 && in_frame) begin
                    chk(run == HALF, "R9 hold before deselect", run, HALF);
                    chk(done == 1'b1, "R9 done with deselect", done, 1);
                    chk(lead_cnt == cur.n, "R4 edge count", lead_cnt, cur.n);
                    chk(rx_data == (cur.mw & mask_of(cur.n)), "R7 R8 received word", rx_data, cur.mw & mask_of(cur.n));
                    chk(srx == (cur.tx & mask_of(cur.n)), "R7 R8 sent word", srx, cur.tx & mask_of(cur.n));
                    void'(q.pop_front());
                    in_frame = 0;
                    frames++;
                end
                run = 1;
            end else if (in_frame && sck != prev_sck) begin
                if (sck != cur.cpol) begin
                    if (lead_cnt == 0) chk(run == HALF, "R3 setup delay", run, HALF);
                    else               chk(run == HALF, "R4 idle half", run, HALF);
                    if (lead_cnt < cur.n) begin
                        if (cur.lsb) srx[lead_cnt] = mosi;
                        else         srx[cur.n-1-lead_cnt] = mosi;
                    end
                    lead_cnt++;
                end else begin
                    chk(run == HALF, "R4 active half", run, HALF);
                    sidx++;
                    if (sidx < cur.n) miso = bit_at(cur, sidx);
                end
                run = 1;
            end else begin
                run++;
                if (done) chk(0, "R9 stray done", done, 0);
                if (cs_n == '1 && !busy) chk(sck == cfg_cpol, "R6 idle level", sck, cfg_cpol);
            end
            prev_cs  = cs_n;
            prev_sck = sck;
        end
    end

    task automatic frame(input logic [31:0] tx, input logic [31:0] mw, input logic [1:0] wc,
                         input bit lsb, input bit cpol, input int sl, input bit mid_start);
        exp_t e;
        int   t;
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        cfg_width = wc; cfg_lsb = lsb; cfg_cpol = cpol; slave = sl[1:0]; tx_data = tx;
        e.tx = tx; e.mw = mw; e.n = nbits(wc); e.lsb = lsb; e.cpol = cpol; e.slave = sl;
        q.push_back(e);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (mid_start) begin
            repeat (3*HALF) @(posedge clk);
            #1;
            start = 1'b1; tx_data = ~tx; slave = slave ^ 2'd1; cfg_lsb = ~lsb; cfg_width = 2'd1;
            @(posedge clk); #1;
            start = 1'b0; tx_data = tx; slave = sl[1:0]; cfg_lsb = lsb; cfg_width = wc;
        end
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk(0, "R9 no done", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R9 watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == '1, "R1 select idle", {28'd0, cs_n}, 32'hF);
        chk(done == 1'b0, "R1 done low", done, 0);
        chk(busy == 1'b0, "R1 busy low", busy, 0);
        chk(sck == 1'b0, "R1 sck idle low", sck, 0);
        @(posedge clk); #1 cfg_cpol = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R1 R6 sck idle high", sck, 1);

        frame(32'h0000_00A5, 32'h0000_003C, 2'd0, 0, 0, 0, 0);
        frame(32'h0000_1234, 32'h0000_BEEF, 2'd1, 1, 1, 2, 0);
        frame(32'hC0DE_F00D, 32'h8765_4321, 2'd2, 0, 1, 3, 0);
        frame(32'h1357_9BDF, 32'hF0E1_D2C3, 2'd3, 1, 0, 1, 0);
        frame(32'hFFFF_FF81, 32'hAAAA_AA5A, 2'd0, 0, 0, 2, 0);   // R8 upper bits ignored
        frame(32'h0000_6D2B, 32'h0000_9119, 2'd1, 0, 0, 1, 1);   // R10 start while busy
        frame(32'h0000_00F0, 32'h0000_0011, 2'd0, 1, 1, 3, 0);   // R11 back to back
        frame(32'h0000_000F, 32'h0000_0088, 2'd0, 1, 1, 3, 0);
        frame(32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 1, 0, 0, 0);
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R10 no pending frame", q.size(), 0);
        chk(cs_n == '1, "R10 select stays idle", {28'd0, cs_n}, 32'hF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule